// File: doc/BRIEF.md
# Ethernet PHY Link Status Poller

This block watches the link state of two Ethernet PHYs without software involvement. A free-running interval counter fires a poll pass, and the pass runs only while the global switch-enable input is high. In each pass the block reads the status register of every port's PHY through a one-at-a-time read request interface to an MDIO master. When a port's link bit differs from the last value it recorded, the block works out the operating mode for that port and drives it on the port's outputs. The mode is a speed code, a duplex flag and a flow-control enable. A per-port force-link-up output then tells the switch MAC that the link may carry traffic.

After a link drop the block reads the status register a second time, because the PHY latches the link bit low. When auto-negotiation has completed, the block takes the best mode that both link partners share from the advertised and partner ability registers. That includes the gigabit control and status registers. When auto-negotiation has not completed, it takes the mode from the PHY's control register.

Top module: `phy_link_poller`

## Requirements
- R1: A poll pass starts only on the cycle in which the interval counter expires (every `POLL_TICKS` cycles) while `sw_enable_i` is high. With `sw_enable_i` low, no read is issued and no output changes.
- R2: Within a pass, every read for port 0 is issued before the first read for port 1.
- R3: A status register (register 1) value of 16'h0000 or 16'hFFFF marks the port as absent. No further read is issued for that port in this pass, and its outputs and stored link state stay as they were.
- R4: The link bit is bit 2 of register 1. If it equals the stored link state of that port, no other register of that port is read in the pass.
- R5: When the link bit shows a drop, the port's `link_force_o` bit is cleared first, then register 1 is read again. The bit from the second read is taken as the new link state, and if it shows link up the mode is resolved.
- R6: For a port whose link comes up, registers 0 and 4 are read, in that order. Registers 5, 9 and 10 follow, in that order, only when register 0 bit 12 (auto-negotiation enabled) and register 1 bit 5 (auto-negotiation complete) are both set.
- R7: With auto-negotiation resolved, `pause_o` of the port is bit 10 of (reg4 AND reg5).
- R8: With auto-negotiation resolved, a six-bit ability word is formed. Bit 5 is 1000 full and bit 4 is 1000 half: these are bits 9 and 8 of reg9 ANDed with bits 11 and 10 of reg10. Bits 3 down to 0 are 100 full, 100 half, 10 full and 10 half, taken from bits 8 down to 5 of (reg4 AND reg5). The highest set bit chooses the mode. An empty word gives 10 half. The speed code on `speed_o` is 0, 1 or 2 for 10, 100 or 1000 Mb/s, and the duplex flag is 1 for full duplex.
- R9: Without resolved auto-negotiation, pause is reg4 bit 10. The speed code is 2 if reg0 bit 6 is set and otherwise reg0 bit 13. Duplex is reg0 bit 8.
- R10: Only one read is outstanding. `rd_req_o` stays high with stable PHY and register addresses until `rd_ack_i`, which carries the 16-bit data.
- R11: After a port's mode outputs are updated for a link that is up, that port's `link_force_o` bit is set.
- R12: After reset all mode and force outputs are 0 and every port's stored link state is unknown. The first valid status read of a port therefore counts as a change, including a link-down read, which triggers the re-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_enable_i | input | 1 | Switch enable; gates the start of poll passes |
| rd_req_o | output | 1 | Read request to the MDIO master |
| rd_phy_o | output | PHY_ADDR_W | PHY address of the request |
| rd_reg_o | output | 5 | Register address of the request |
| rd_ack_i | input | 1 | One-cycle read completion |
| rd_data_i | input | 16 | Read data, valid with `rd_ack_i` |
| speed_o | output | 2*NUM_PORTS | Speed code per port, 2 bits each, port 0 in the low bits |
| duplex_o | output | NUM_PORTS | Full-duplex flag per port |
| pause_o | output | NUM_PORTS | Flow-control enable per port |
| link_force_o | output | NUM_PORTS | Force-link-up per port |

## Verification
The bench checks the link-drop re-read with a PHY model whose first status read after a drop shows the link down while the second shows it up. A design that trusts the first read would leave the port down, and a design that never clears the force bit would show no falling edge. The bench walks the ability-priority ladder with vectors in which lower modes are also shared, so a wrong order of thresholds or a misaligned gigabit shift picks the wrong speed. The bench also covers absent PHYs (all-zero and all-one status), a repeated unchanged link, auto-negotiation enabled but not complete, and a first-ever link-down read after reset. A design that skips any of these reads the wrong register count or clobbers stored outputs.

// File: rtl/phy_poll_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the PHY link poller.
// Assumes IEEE clause-22 register numbering for the PHY.
package phy_poll_pkg;

    localparam int unsigned REG_ADDR_W = 5;
    localparam int unsigned DATA_W     = 16;

    localparam logic [REG_ADDR_W-1:0] REG_CTRL  = 5'd0;
    localparam logic [REG_ADDR_W-1:0] REG_STAT  = 5'd1;
    localparam logic [REG_ADDR_W-1:0] REG_ADV   = 5'd4;
    localparam logic [REG_ADDR_W-1:0] REG_LPA   = 5'd5;
    localparam logic [REG_ADDR_W-1:0] REG_GCTL  = 5'd9;
    localparam logic [REG_ADDR_W-1:0] REG_GSTAT = 5'd10;

    localparam logic [1:0] SPD_10   = 2'd0;
    localparam logic [1:0] SPD_100  = 2'd1;
    localparam logic [1:0] SPD_1000 = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STAT,
        ST_STAT_AGAIN,
        ST_CTRL,
        ST_ADV,
        ST_LPA,
        ST_GCTL,
        ST_GSTAT,
        ST_APPLY,
        ST_NEXT
    } poll_state_t;

    // Resolved operating mode of one port.
    typedef struct packed {
        logic [1:0] speed;
        logic       duplex;
        logic       pause;
    } link_cfg_t;

    // Only the PHY register bits the resolution needs.
    typedef struct packed {
        logic       an_enable;    // reg0 bit 12
        logic       speed_lsb;    // reg0 bit 13
        logic       speed_msb;    // reg0 bit 6
        logic       full_duplex;  // reg0 bit 8
        logic       an_complete;  // reg1 bit 5
        logic [4:0] own_abil;     // reg4 {bit 10, bits 8:5}
        logic [4:0] peer_abil;    // reg5 {bit 10, bits 8:5}
        logic [1:0] own_gig;      // reg9 bits 9:8
        logic [1:0] peer_gig;     // reg10 bits 11:10
    } phy_regs_t;

endpackage

// File: rtl/phy_poll_ticker.sv
`timescale 1ns/1ps
// Poll interval counter: pulses tick_o for one cycle every PERIOD cycles.
// Assumes PERIOD >= 1; it runs freely, and the consumer gates the pulse.
module phy_poll_ticker #(
    parameter int unsigned PERIOD = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles and wrap at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (PERIOD > 1) begin : g_chk
            assert_tick_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("poll tick lasted more than one cycle");
        end
    endgenerate

endmodule

// File: rtl/phy_ability_resolver.sv
`timescale 1ns/1ps
// Combinational mode resolution from captured PHY register bits.
// With auto-negotiation enabled and complete: best common ability by
// six-level priority. Otherwise: forced mode bits from the control register.
module phy_ability_resolver
    import phy_poll_pkg::*;
(
    input  phy_regs_t regs_i,
    output link_cfg_t cfg_o
);
    logic       aneg_done;
    logic [4:0] common_lo;
    logic [1:0] common_gig;
    logic [5:0] ability;

    // Intersect own and partner abilities.
    always_comb begin
        aneg_done  = regs_i.an_enable & regs_i.an_complete;
        common_lo  = regs_i.own_abil & regs_i.peer_abil;
        common_gig = regs_i.own_gig & regs_i.peer_gig;
        ability    = {common_gig, common_lo[3:0]};
    end

    // Pick the mode: priority ladder or forced bits.
    always_comb begin
        cfg_o = '0;
        if (aneg_done) begin
            cfg_o.pause = common_lo[4];
            if (ability[5])      begin cfg_o.speed = SPD_1000; cfg_o.duplex = 1'b1; end
            else if (ability[4]) begin cfg_o.speed = SPD_1000; cfg_o.duplex = 1'b0; end
            else if (ability[3]) begin cfg_o.speed = SPD_100;  cfg_o.duplex = 1'b1; end
            else if (ability[2]) begin cfg_o.speed = SPD_100;  cfg_o.duplex = 1'b0; end
            else if (ability[1]) begin cfg_o.speed = SPD_10;   cfg_o.duplex = 1'b1; end
            else                 begin cfg_o.speed = SPD_10;   cfg_o.duplex = 1'b0; end
        end else begin
            cfg_o.pause  = regs_i.own_abil[4];
            cfg_o.speed  = regs_i.speed_msb ? SPD_1000 : {1'b0, regs_i.speed_lsb};
            cfg_o.duplex = regs_i.full_duplex;
        end
    end

    always_comb begin
        assert_speed_code_legal_R8: assert (cfg_o.speed != 2'd3)
            else $error("resolved speed code out of range");
    end

endmodule

// File: rtl/phy_port_status.sv
`timescale 1ns/1ps
// Per-port state: recorded link state (with unknown after reset),
// resolved mode outputs and the force-link-up bit.
// Assumes strobes are only acted on while sel_i marks this port as serviced.
module phy_port_status
    import phy_poll_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_i,
    input  logic      clr_force_i,
    input  logic      mark_down_i,
    input  logic      load_i,
    input  link_cfg_t cfg_i,
    output logic      known_o,
    output logic      link_o,
    output link_cfg_t cfg_o,
    output logic      force_o
);
    // Update recorded state and outputs for the serviced port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            known_o <= 1'b0;
            link_o  <= 1'b0;
            cfg_o   <= '0;
            force_o <= 1'b0;
        end else if (sel_i) begin
            if (clr_force_i) force_o <= 1'b0;
            if (mark_down_i) begin
                known_o <= 1'b1;
                link_o  <= 1'b0;
            end
            if (load_i) begin
                known_o <= 1'b1;
                link_o  <= 1'b1;
                cfg_o   <= cfg_i;
                force_o <= 1'b1;
            end
        end
    end

    assert_cfg_only_when_serviced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(sel_i))
        else $error("port mode changed while port not serviced");

    assert_force_set_with_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_o) |-> link_o && known_o)
        else $error("force-link-up set without recorded link");

endmodule

// File: rtl/phy_link_poller.sv
`timescale 1ns/1ps
// Top: sequences the PHY register reads of each poll pass, detects link
// changes per port and loads the resolved mode into the port state.
// Assumes the MDIO master returns one rd_ack_i per accepted request and
// that rd_req_o may stay high across back-to-back reads.
module phy_link_poller
    import phy_poll_pkg::*;
#(
    parameter int unsigned NUM_PORTS  = 2,
    parameter int unsigned POLL_TICKS = 100_000_000,
    parameter int unsigned PHY_ADDR_W = 5,
    parameter logic [NUM_PORTS*PHY_ADDR_W-1:0] PHY_ADDRS = {5'd1, 5'd0}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sw_enable_i,
    output logic                    rd_req_o,
    output logic [PHY_ADDR_W-1:0]   rd_phy_o,
    output logic [REG_ADDR_W-1:0]   rd_reg_o,
    input  logic                    rd_ack_i,
    input  logic [DATA_W-1:0]       rd_data_i,
    output logic [2*NUM_PORTS-1:0]  speed_o,
    output logic [NUM_PORTS-1:0]    duplex_o,
    output logic [NUM_PORTS-1:0]    pause_o,
    output logic [NUM_PORTS-1:0]    link_force_o
);
    localparam int unsigned PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [PIDX_W-1:0] LAST_PORT = PIDX_W'(NUM_PORTS - 1);

    poll_state_t       state_q;
    logic [PIDX_W-1:0] port_q;
    phy_regs_t         regs_q;
    link_cfg_t         cfg_new;
    logic              tick;
    logic              busy;

    logic [NUM_PORTS-1:0] known_w;
    logic [NUM_PORTS-1:0] link_w;
    logic [NUM_PORTS-1:0] force_w;
    link_cfg_t            cfg_w [NUM_PORTS];

    logic cur_known, cur_link, stat_absent, new_link;
    logic clr_force, mark_down, load_cfg;

    phy_poll_ticker #(.PERIOD(POLL_TICKS)) u_ticker (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    phy_ability_resolver u_resolver (
        .regs_i (regs_q),
        .cfg_o  (cfg_new)
    );

    assign busy = (state_q != ST_IDLE);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            link_cfg_t cfg_p;
            phy_port_status u_status (
                .clk         (clk),
                .rst_n       (rst_n),
                .sel_i       (busy && (port_q == PIDX_W'(p))),
                .clr_force_i (clr_force),
                .mark_down_i (mark_down),
                .load_i      (load_cfg),
                .cfg_i       (cfg_new),
                .known_o     (known_w[p]),
                .link_o      (link_w[p]),
                .cfg_o       (cfg_p),
                .force_o     (force_w[p])
            );
            assign cfg_w[p]        = cfg_p;
            assign speed_o[2*p +: 2] = cfg_p.speed;
            assign duplex_o[p]     = cfg_p.duplex;
            assign pause_o[p]      = cfg_p.pause;
        end
    endgenerate

    assign link_force_o = force_w;

    // Decode the status word and derive the per-port update strobes.
    always_comb begin
        cur_known   = known_w[port_q];
        cur_link    = link_w[port_q];
        stat_absent = (rd_data_i == '0) || (rd_data_i == '1);
        new_link    = rd_data_i[2];
        clr_force   = (state_q == ST_STAT) && rd_ack_i && !stat_absent && !new_link
                      && (!cur_known || cur_link);
        mark_down   = (state_q == ST_STAT_AGAIN) && rd_ack_i && !new_link;
        load_cfg    = (state_q == ST_APPLY);
    end

    // Request outputs follow the read state.
    always_comb begin
        rd_req_o = 1'b1;
        rd_reg_o = REG_STAT;
        case (state_q)
            ST_STAT, ST_STAT_AGAIN: rd_reg_o = REG_STAT;
            ST_CTRL:                rd_reg_o = REG_CTRL;
            ST_ADV:                 rd_reg_o = REG_ADV;
            ST_LPA:                 rd_reg_o = REG_LPA;
            ST_GCTL:                rd_reg_o = REG_GCTL;
            ST_GSTAT:               rd_reg_o = REG_GSTAT;
            default:                rd_req_o = 1'b0;
        endcase
        rd_phy_o = PHY_ADDRS[int'(port_q)*PHY_ADDR_W +: PHY_ADDR_W];
    end

    // Pass sequencer: walks ports in order and captures register bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
            regs_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (tick && sw_enable_i) begin
                    state_q <= ST_STAT;
                    port_q  <= '0;
                end
                ST_STAT: if (rd_ack_i) begin
                    regs_q.an_complete <= rd_data_i[5];
                    if (stat_absent)                         state_q <= ST_NEXT;
                    else if (cur_known && cur_link == new_link) state_q <= ST_NEXT;
                    else if (!new_link)                      state_q <= ST_STAT_AGAIN;
                    else                                     state_q <= ST_CTRL;
                end
                ST_STAT_AGAIN: if (rd_ack_i) begin
                    regs_q.an_complete <= rd_data_i[5];
                    state_q <= new_link ? ST_CTRL : ST_NEXT;
                end
                ST_CTRL: if (rd_ack_i) begin
                    regs_q.an_enable   <= rd_data_i[12];
                    regs_q.speed_lsb   <= rd_data_i[13];
                    regs_q.speed_msb   <= rd_data_i[6];
                    regs_q.full_duplex <= rd_data_i[8];
                    state_q <= ST_ADV;
                end
                ST_ADV: if (rd_ack_i) begin
                    regs_q.own_abil <= {rd_data_i[10], rd_data_i[8:5]};
                    state_q <= (regs_q.an_enable && regs_q.an_complete) ? ST_LPA : ST_APPLY;
                end
                ST_LPA: if (rd_ack_i) begin
                    regs_q.peer_abil <= {rd_data_i[10], rd_data_i[8:5]};
                    state_q <= ST_GCTL;
                end
                ST_GCTL: if (rd_ack_i) begin
                    regs_q.own_gig <= rd_data_i[9:8];
                    state_q <= ST_GSTAT;
                end
                ST_GSTAT: if (rd_ack_i) begin
                    regs_q.peer_gig <= rd_data_i[11:10];
                    state_q <= ST_APPLY;
                end
                ST_APPLY: state_q <= ST_NEXT;
                ST_NEXT: begin
                    if (port_q == LAST_PORT) begin
                        state_q <= ST_IDLE;
                    end else begin
                        port_q  <= port_q + 1'b1;
                        state_q <= ST_STAT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_reg_o) && $stable(rd_phy_o))
        else $error("read request withdrawn or changed before acknowledge");

    assert_idle_without_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !sw_enable_i |=> (state_q == ST_IDLE))
        else $error("poll pass started while switch disabled");

    assert_force_low_on_reread_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STAT_AGAIN) |-> !link_force_o[port_q])
        else $error("force-link-up still set during status re-read");

    assert_port_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NEXT) && (port_q != LAST_PORT) |=> (port_q == $past(port_q) + 1'b1))
        else $error("ports not serviced in ascending order");

endmodule

// File: tb/phy_link_poller_tb.sv
`timescale 1ns/1ps
module phy_link_poller_tb;
    localparam int PT = 200;

    typedef struct packed {
        logic [15:0] adv, lpa, gadv, glpa;
        logic [1:0]  spd;
        logic        dup, pau;
    } vec_t;

    // Resolved-autoneg vectors and their expected mode.
    localparam vec_t VEC [8] = '{
        '{16'h05E1, 16'h05E1, 16'h0300, 16'h0C00, 2'd2, 1'b1, 1'b1},
        '{16'h0041, 16'h0021, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b0},
        '{16'h05E1, 16'h01E1, 16'h0100, 16'h0C00, 2'd2, 1'b0, 1'b0},
        '{16'h01E1, 16'h0181, 16'h0000, 16'h0000, 2'd1, 1'b1, 1'b0},
        '{16'h05E1, 16'h05E1, 16'h0300, 16'h0400, 2'd2, 1'b0, 1'b1},
        '{16'h00E1, 16'h0481, 16'h0000, 16'h0000, 2'd1, 1'b0, 1'b0},
        '{16'h0461, 16'h0441, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1},
        '{16'h0021, 16'h0021, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, sw_en;
    logic        rd_req, rd_ack;
    logic [4:0]  rd_phy, rd_reg;
    logic [15:0] rd_data;
    logic [3:0]  speed;
    logic [1:0]  duplex, pause, force_up;

    phy_link_poller #(.POLL_TICKS(PT)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_enable_i(sw_en),
        .rd_req_o(rd_req), .rd_phy_o(rd_phy), .rd_reg_o(rd_reg),
        .rd_ack_i(rd_ack), .rd_data_i(rd_data),
        .speed_o(speed), .duplex_o(duplex), .pause_o(pause), .link_force_o(force_up)
    );

    int total = 0, bad = 0;
    logic [15:0] preg [0:1][0:15];
    logic        latch_arm [0:1];
    logic [4:0]  log_phy [0:4095];
    logic [4:0]  log_reg [0:4095];
    int          log_n = 0;
    int          fall0 = 0;
    logic        busy;
    logic [4:0]  cap_phy, cap_reg;
    int          wt;

    // MDIO master model: fixed latency, one read at a time, latched-low link.
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack <= 1'b0; busy <= 1'b0; rd_data <= '0;
        end else if (rd_ack) begin
            rd_ack <= 1'b0;
        end else if (busy) begin
            if (wt == 0) begin
                if (cap_reg == 5'd1 && latch_arm[cap_phy[0]]) begin
                    rd_data <= preg[cap_phy[0]][1] & ~16'h0004;
                    latch_arm[cap_phy[0]] <= 1'b0;
                end else begin
                    rd_data <= preg[cap_phy[0]][cap_reg[3:0]];
                end
                rd_ack <= 1'b1;
                busy   <= 1'b0;
            end else begin
                wt <= wt - 1;
            end
        end else if (rd_req) begin
            busy <= 1'b1; wt <= 2;
            cap_phy <= rd_phy; cap_reg <= rd_reg;
            log_phy[log_n] <= rd_phy; log_reg[log_n] <= rd_reg;
            log_n <= log_n + 1;
        end
    end

    always @(negedge force_up[0]) fall0 <= fall0 + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_pass(output int first);
        int idle;
        first = log_n;
        do @(negedge clk); while (rd_req !== 1'b1);
        idle = 0;
        while (idle < 20) begin
            @(negedge clk);
            if (rd_req || rd_ack) idle = 0; else idle++;
        end
    endtask

    function automatic int reads(input int first, input int phy, input int rg);
        int n = 0;
        for (int i = first; i < log_n; i++)
            if (int'(log_phy[i]) == phy && (rg < 0 || int'(log_reg[i]) == rg)) n++;
        return n;
    endfunction

    task automatic set_vec(input vec_t v);
        preg[0][0] = 16'h1000; preg[0][1] = 16'h0024;
        preg[0][4] = v.adv; preg[0][5] = v.lpa;
        preg[0][9] = v.gadv; preg[0][10] = v.glpa;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int f, last0, first1, f0;
        for (int p = 0; p < 2; p++) begin
            latch_arm[p] = 1'b0;
            for (int r = 0; r < 16; r++) preg[p][r] = 16'h0000;
        end
        preg[0][1] = 16'h0020;   // present, link down
        preg[1][1] = 16'hFFFF;   // absent
        rst_n = 1'b0; sw_en = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R12 reset outputs", {speed, duplex, pause, force_up}, 0);
        check("R12 no request in reset", rd_req, 0);
        rst_n = 1'b1;

        // First pass: unknown state makes a down link a change.
        run_pass(f);
        check("R2 first read is port0 status", {log_phy[f], log_reg[f]}, {5'd0, 5'd1});
        check("R12 unknown state re-reads status", reads(f, 0, 1), 2);
        check("R3 absent all-ones single read", reads(f, 1, -1), 1);
        check("R3 absent port force low", force_up, 0);

        run_pass(f);
        check("R4 unchanged link single read", reads(f, 0, -1), 1);

        // Vector table on port 0.
        for (int k = 0; k < 8; k++) begin
            set_vec(VEC[k]);
            run_pass(f);
            check($sformatf("R8 vec%0d speed", k), speed[1:0], VEC[k].spd);
            check($sformatf("R8 vec%0d duplex", k), duplex[0], VEC[k].dup);
            check($sformatf("R7 vec%0d pause", k), pause[0], VEC[k].pau);
            check($sformatf("R11 vec%0d force", k), force_up[0], 1);
            check($sformatf("R6 vec%0d read count", k), reads(f, 0, -1), 6);
            if (k == 0)
                check("R6 read order", {log_reg[f], log_reg[f+1], log_reg[f+2],
                      log_reg[f+3], log_reg[f+4], log_reg[f+5]},
                      {5'd1, 5'd0, 5'd4, 5'd5, 5'd9, 5'd10});
            preg[0][1] = 16'h0020;
            run_pass(f);
            check($sformatf("R5 vec%0d drop clears force", k), force_up[0], 0);
            check($sformatf("R5 vec%0d drop re-read", k), reads(f, 0, 1), 2);
        end

        // Port 1 without autoneg: forced mode bits.
        preg[1][1] = 16'h0004; preg[1][0] = 16'h0140; preg[1][4] = 16'h0400;
        run_pass(f);
        check("R9 forced speed 1000", speed[3:2], 2);
        check("R9 forced duplex", duplex[1], 1);
        check("R9 pause from reg4", pause[1], 1);
        check("R11 port1 force", force_up[1], 1);
        check("R6 no autoneg three reads", reads(f, 1, -1), 3);
        last0 = -1; first1 = -1;
        for (int i = f; i < log_n; i++) begin
            if (log_phy[i] == 5'd0) last0 = i;
            if (log_phy[i] == 5'd1 && first1 < 0) first1 = i;
        end
        check("R2 port0 reads precede port1", last0 < first1, 1);

        preg[1][1] = 16'h0000;
        run_pass(f);
        check("R3 absent all-zero keeps force", force_up[1], 1);
        check("R3 absent all-zero keeps speed", speed[3:2], 2);
        check("R3 absent all-zero single read", reads(f, 1, -1), 1);

        preg[1][1] = 16'h0004;
        run_pass(f);
        check("R3 stored state kept across absence", reads(f, 1, -1), 1);

        preg[1][1] = 16'h0010;
        run_pass(f);
        check("R5 port1 drop clears force", force_up[1], 0);

        preg[1][0] = 16'h3100; preg[1][1] = 16'h0004;
        preg[1][4] = 16'h0000; preg[1][5] = 16'hFFFF;
        run_pass(f);
        check("R9 enabled but incomplete speed", speed[3:2], 1);
        check("R9 enabled but incomplete duplex", duplex[1], 1);
        check("R9 enabled but incomplete pause", pause[1], 0);
        check("R6 incomplete autoneg three reads", reads(f, 1, -1), 3);

        // Latched-low link: first status read down, second up.
        set_vec(VEC[0]);
        run_pass(f);
        check("R11 port0 up again", force_up[0], 1);
        preg[0][4] = 16'h01E1; preg[0][5] = 16'h01E1; preg[0][9] = 0; preg[0][10] = 0;
        latch_arm[0] = 1'b1;
        f0 = fall0;
        run_pass(f);
        check("R5 latched drop re-read", reads(f, 0, 1), 2);
        check("R5 force cleared before re-read", fall0 - f0, 1);
        check("R5 second read up sets force", force_up[0], 1);
        check("R5 second read resolves speed", speed[1:0], 1);
        check("R5 second read resolves duplex", duplex[0], 1);
        check("R7 second read pause", pause[0], 0);

        // Switch disabled: no polling at all.
        sw_en = 1'b0;
        f = log_n;
        preg[0][1] = 16'h0020;
        repeat (3*PT) @(negedge clk);
        check("R1 no reads while disabled", log_n - f, 0);
        check("R1 outputs held while disabled", force_up[0], 1);
        sw_en = 1'b1;
        run_pass(f);
        check("R1 polling resumes when enabled", force_up[0], 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule